// File: doc/BRIEF.md
# Power-Good Supervisor

This block generates the power-good indication of a synchronous buck regulator. It watches the enable input, the soft-start sequencing signals, the output-voltage window flags and the fault flag from the protection logic. From these it drives one registered release request for the open-drain power-good pin. When the request is low the pad pulls the pin down. When it is high the pad leaves the pin at high impedance, and an external resistor pulls the pin up.

After soft-start finishes, the block waits for a fixed number of clock cycles before it first releases the pin. The wait length is a parameter. After that wait, the pin is released only while the output voltage is inside its window. The window comparator outputs arrive without a clock, so the block passes them through a two-stage synchronizer. A fault pulls the pin low and is latched. The pin stays low until the next soft-start attempt begins, even if the voltage returns to its window before then.

Top module: `pg_supervisor`

## Requirements
- R1: While the synchronous reset is high, and on the first clock after it, `pg_release_o` is 0.
- R2: When `en_i` is 0 at a rising edge, `pg_release_o` is 0 after that edge.
- R3: When `ss_active_i` is 1 at a rising edge, `pg_release_o` is 0 after that edge.
- R4: Say `ss_done_i` is sampled at 1 on edge E, and enable, window and fault conditions are clean after that. Then `pg_release_o` first becomes 1 at edge E+DELAY_CYCLES+1. It is 0 at every edge before that one.
- R5: After the delay has expired, `uv_i` or `ov_i` at 1 (1 means outside the window) pulls `pg_release_o` to 0 at the third rising edge after the flag changes. The first two edges are the synchronizer and the third is the output register.
- R6: With no latched fault, `pg_release_o` returns to 1 at the third rising edge after both window flags return to 0.
- R7: `fault_i` at 1 on an edge forces `pg_release_o` to 0 after that edge. The fault is latched, so the output stays 0 after `fault_i` falls, even with clean window flags.
- R8: The latched fault clears only at a rising transition of `ss_active_i`, which marks a new soft-start attempt. After that attempt, the delay of R4 restarts from the next `ss_done_i`.
- R9: Once the delay has expired, the delay counter saturates. With clean inputs, `pg_release_o` stays 1 for any length of time and never wraps back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Regulator enable |
| ss_active_i | input | 1 | High while soft-start is running |
| ss_done_i | input | 1 | One-cycle pulse at soft-start completion |
| uv_i | input | 1 | Asynchronous undervoltage window flag |
| ov_i | input | 1 | Asynchronous overvoltage window flag |
| fault_i | input | 1 | Fault-active flag from the protection sequencer |
| pg_release_o | output | 1 | 1 = leave the pin at high impedance, 0 = pull the pin low |

## Verification
Assertions check these behaviours on every cycle:
- A low enable, an active soft-start or an active fault is always followed by a pulled-low output.
- The output never rises unless the delay has expired.
- The delay counter never passes its limit.
- A latched fault holds until a soft-start begins.

Only the bench scenarios can show the exact timing:
- the edge on which the release first appears after `ss_done_i`;
- the three-edge latency of window violations and window recovery;
- the fault latch outliving a window recovery;
- the delay restarting after a new soft-start.

The bench runs these scenarios against a cycle model it keeps itself.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic uv;
    logic ov;
  } win_flags_t;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pg_delay_timer.sv
module pg_delay_timer #(
  parameter int unsigned DELAY_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic arm_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYCLES);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = armed_q && (cnt_q == LIMIT);

  // R9: counter saturates at its limit
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (expired_o && !hold_i && !arm_i) |=> expired_o);
endmodule

// File: rtl/pg_fault_latch.sv
module pg_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  input  logic restart_i,
  output logic latched_o
);
  always_ff @(posedge clk) begin
    if (rst)            latched_o <= 1'b0;
    else if (fault_i)   latched_o <= 1'b1;
    else if (restart_i) latched_o <= 1'b0;
  end

  // R8: only a soft-start attempt clears the latch
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (latched_o && !restart_i) |=> latched_o);
  // R7: a fault is always captured
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> latched_o);
endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor #(
  parameter int unsigned DELAY_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic ss_active_i,
  input  logic ss_done_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic fault_i,
  output logic pg_release_o
);
  import pg_pkg::*;

  win_flags_t win_raw, win_sync;
  logic       ss_prev_q;
  logic       ss_start;
  logic       delay_hold;
  logic       delay_done;
  logic       fault_held;

  assign win_raw.uv = uv_i;
  assign win_raw.ov = ov_i;

  pg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (win_raw),
    .q_o (win_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) ss_prev_q <= 1'b0;
    else     ss_prev_q <= ss_active_i;
  end
  assign ss_start   = ss_active_i && !ss_prev_q;
  assign delay_hold = !en_i || ss_active_i;

  pg_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .hold_i    (delay_hold),
    .arm_i     (ss_done_i),
    .expired_o (delay_done)
  );

  pg_fault_latch u_fault (
    .clk       (clk),
    .rst       (rst),
    .fault_i   (fault_i),
    .restart_i (ss_start),
    .latched_o (fault_held)
  );

  always_ff @(posedge clk) begin
    if (rst) pg_release_o <= 1'b0;
    else     pg_release_o <= en_i && !ss_active_i && delay_done &&
                             !win_sync.uv && !win_sync.ov &&
                             !fault_held && !fault_i;
  end

  // R2
  a_r2_en_low: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pg_release_o);
  // R3
  a_r3_softstart: assert property (@(posedge clk) disable iff (rst)
    ss_active_i |=> !pg_release_o);
  // R7
  a_r7_fault_low: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> !pg_release_o);
  // R4
  a_r4_rise_after_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_release_o) |-> $past(delay_done));
  // R1
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !pg_release_o);
endmodule

// File: tb/pg_supervisor_test.sv
module pg_supervisor_test;
  localparam int DLY = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, ssa = 1'b0, ssd = 1'b0, uv = 1'b0, ov = 1'b0, flt = 1'b0;
  logic pg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // model state
  int m_uvm, m_uvs, m_ovm, m_ovs, m_prev, m_arm, m_cnt, m_lat, m_pg;

  always #5 clk = ~clk;

  pg_supervisor #(.DELAY_CYCLES(DLY)) uut (
    .clk(clk), .rst(rst), .en_i(en), .ss_active_i(ssa), .ss_done_i(ssd),
    .uv_i(uv), .ov_i(ov), .fault_i(flt), .pg_release_o(pg)
  );

  always @(posedge clk) begin
    int n_pg;
    if (rst) begin
      m_uvm = 0; m_uvs = 0; m_ovm = 0; m_ovs = 0; m_prev = 0;
      m_arm = 0; m_cnt = 0; m_lat = 0; m_pg = 0;
    end else begin
      n_pg = (en && !ssa && m_arm == 1 && m_cnt == DLY && m_uvs == 0 &&
              m_ovs == 0 && m_lat == 0 && !flt) ? 1 : 0;
      if (flt) m_lat = 1;
      else if (ssa && m_prev == 0) m_lat = 0;
      if (!en || ssa) begin m_arm = 0; m_cnt = 0; end
      else if (ssd) begin m_arm = 1; m_cnt = 0; end
      else if (m_arm == 1 && m_cnt < DLY) m_cnt++;
      m_uvs = m_uvm; m_uvm = uv;
      m_ovs = m_ovm; m_ovm = ov;
      m_prev = ssa;
      m_pg = n_pg;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pg_release_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare against the model at the falling edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, pg, m_pg[0]);
    end
  endtask

  initial begin
    tag = "R1"; tick(3);
    rst = 1'b0; tick(1);
    check("R1", pg, 1'b0);

    tag = "R3"; en = 1'b1; ssa = 1'b1; tick(6);
    ssa = 1'b0; ssd = 1'b1; tick(1); ssd = 1'b0;
    tag = "R4"; tick(DLY - 1);
    check("R4", pg, 1'b0);
    tick(2);
    check("R4", pg, 1'b1);

    tag = "R9"; tick(4 * DLY);
    check("R9", pg, 1'b1);

    tag = "R5"; uv = 1'b1; tick(2);
    check("R5", pg, 1'b1);
    tick(1);
    check("R5", pg, 1'b0);
    tick(3);
    tag = "R6"; uv = 1'b0; tick(3);
    check("R6", pg, 1'b1);
    tag = "R5"; ov = 1'b1; tick(4);
    check("R5", pg, 1'b0);
    tag = "R6"; ov = 1'b0; tick(4);
    check("R6", pg, 1'b1);

    tag = "R7"; flt = 1'b1; tick(1);
    check("R7", pg, 1'b0);
    flt = 1'b0; tick(DLY + 5);
    check("R7", pg, 1'b0);

    tag = "R8"; ssd = 1'b1; tick(1); ssd = 1'b0; tick(DLY + 4);
    check("R8", pg, 1'b0);
    ssa = 1'b1; tick(3);
    ssa = 1'b0; ssd = 1'b1; tick(1); ssd = 1'b0;
    tick(DLY + 3);
    check("R8", pg, 1'b1);

    tag = "R2"; en = 1'b0; tick(1);
    check("R2", pg, 1'b0);
    ssd = 1'b1; tick(1); ssd = 1'b0; tick(DLY + 4);
    check("R2", pg, 1'b0);
    en = 1'b1; tick(DLY + 4);
    check("R2", pg, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule